// File: doc/BRIEF.md
# Frame-Aligned Byte Deserializer with Free-Running Output Tick

This block gathers a serial bit stream into bytes through three byte-wide stages. A shift stage takes one bit on every bit-enable cycle. A holding stage captures the completed byte whenever the upstream aligner marks a byte boundary. An output stage copies the holding stage on a free-running byte-rate tick. That tick has no fixed phase relation to the boundary.

When the stream realigns, only the internal load point moves. The output tick keeps its period and is never shortened or stretched. As a result, the delay from a byte's last bit to its appearance on the parallel bus varies from one to eight bit periods, depending on where the boundary falls relative to the tick. The boundary search, clock recovery and any loopback selection sit outside this block.

Top module: `byte_deser_top`

## Requirements
- R1: While reset (`rst_n` low) is asserted, all three stages are cleared, and `par_out` reads 0x00 after reset is released until the first tick.
- R2: The shift stage advances only on cycles with `bit_en` high. A boundary strobe on a cycle with `bit_en` low has no effect on the holding stage.
- R3: On a cycle with both `bit_en` and `byte_mark` high, the holding stage loads the last 8 received bits, including the current one. With `MSB_FIRST`=1, the earliest of those bits is placed in bit 7 and the current bit in bit 0.
- R4: On a cycle with `out_tick` high, `par_out` takes the holding-stage value present before that edge. A boundary load in the same cycle therefore appears only at the next tick.
- R5: If two boundary loads occur between two ticks, the next tick outputs the newer byte.
- R6: If no boundary load occurs between two ticks, the second tick presents the same byte again.
- R7: `par_out` changes only on the edge following an `out_tick` cycle. Boundary strobes and realignment never move or add output updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Qualifies one serial bit period |
| bit_in | input | 1 | Serial data bit |
| byte_mark | input | 1 | Byte boundary from the aligner, valid with `bit_en` |
| out_tick | input | 1 | Free-running byte-rate output update tick |
| par_out | output | 8 | Parallel output byte |

## Verification
The hardest case to reach is a realignment that puts two boundary loads inside one tick interval, or none at all. With a steady stream, each interval holds exactly one load. The stimulus moves the boundary phase at random times while the tick counter runs on undisturbed, so both the collision case and the starved case occur. Directed cases also place a load and a tick on the same bit, and a boundary strobe on a cycle without a bit.

// File: rtl/deser_pkg.sv
`timescale 1ns/1ps
package deser_pkg;
   parameter int unsigned DEFAULT_W = 8;

   // shift one bit into a word, direction chosen by msb_first
   function automatic logic [DEFAULT_W-1:0] push_bit(
      input logic [DEFAULT_W-1:0] word,
      input logic                 b,
      input bit                   msb_first);
      if (msb_first)
         return {word[DEFAULT_W-2:0], b};
      else
         return {b, word[DEFAULT_W-1:1]};
   endfunction
endpackage

// File: rtl/deser_shift.sv
`timescale 1ns/1ps
module deser_shift #(
   parameter int unsigned W         = deser_pkg::DEFAULT_W,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bit_en,
   input  logic         bit_in,
   output logic [W-1:0] sr_q,
   output logic [W-1:0] sr_next
);
   generate
      if (W < 2) begin : g_bad_w
         $error("deser_shift: W must be at least 2");
      end
      if (MSB_FIRST) begin : g_msb
         assign sr_next = {sr_q[W-2:0], bit_in};
      end else begin : g_lsb
         assign sr_next = {bit_in, sr_q[W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sr_q <= '0;
      else if (bit_en)
         sr_q <= sr_next;
   end

   // R2: no movement without a bit period
   p_shift_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(sr_q));
endmodule

// File: rtl/deser_hold.sv
`timescale 1ns/1ps
module deser_hold #(
   parameter int unsigned W = deser_pkg::DEFAULT_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bit_en,
   input  logic         byte_mark,
   input  logic [W-1:0] word_in,
   output logic [W-1:0] hold_q
);
   logic load;
   assign load = bit_en & byte_mark;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= '0;
      else if (load)
         hold_q <= word_in;
   end

   // R2 / R3: holding stage moves only on a qualified boundary
   p_hold_only_on_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bit_en && byte_mark) |=> $stable(hold_q));
   // R3: a boundary captures the word presented by the shift stage
   p_hold_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && byte_mark) |=> hold_q == $past(word_in));
endmodule

// File: rtl/deser_out.sv
`timescale 1ns/1ps
module deser_out #(
   parameter int unsigned W = deser_pkg::DEFAULT_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         out_tick,
   input  logic [W-1:0] hold_in,
   output logic [W-1:0] out_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         out_q <= '0;
      else if (out_tick)
         out_q <= hold_in;
   end

   // R7: output timing set by the tick alone
   p_out_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_tick |=> $stable(out_q));
   // R4: tick copies the pre-edge holding value
   p_out_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_tick |=> out_q == $past(hold_in));
endmodule

// File: rtl/byte_deser_top.sv
`timescale 1ns/1ps
module byte_deser_top #(
   parameter int unsigned W         = deser_pkg::DEFAULT_W,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bit_en,
   input  logic         bit_in,
   input  logic         byte_mark,
   input  logic         out_tick,
   output logic [W-1:0] par_out
);
   logic [W-1:0] sr_q;
   logic [W-1:0] sr_next;
   logic [W-1:0] hold_q;

   deser_shift #(.W(W), .MSB_FIRST(MSB_FIRST)) i_shift (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .sr_q(sr_q), .sr_next(sr_next));

   deser_hold #(.W(W)) i_hold (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .byte_mark(byte_mark),
      .word_in(sr_next), .hold_q(hold_q));

   deser_out #(.W(W)) i_out (
      .clk(clk), .rst_n(rst_n), .out_tick(out_tick),
      .hold_in(hold_q), .out_q(par_out));

   // R1: reset leaves the bus at zero
   p_reset_zero_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> par_out == '0);
endmodule

// File: tb/test_byte_deser_top.sv
`timescale 1ns/1ps
module test_byte_deser_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0, bit_in = 1'b0, byte_mark = 1'b0, out_tick = 1'b0;
   logic [7:0] par_out;
   int         n_chk = 0, n_err = 0;
   logic [7:0] m_sr, m_hold, m_out;

   always #10 clk = ~clk;

   byte_deser_top i_byte_deser_top (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .byte_mark(byte_mark), .out_tick(out_tick), .par_out(par_out));

   // reference model from the requirements
   function automatic logic [7:0] shl(input logic [7:0] w, input logic b);
      return {w[6:0], b};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sr = 8'h00; m_hold = 8'h00; m_out = 8'h00;
      end else begin
         if (out_tick) m_out = m_hold;
         if (bit_en && byte_mark) m_hold = shl(m_sr, bit_in);
         if (bit_en) m_sr = shl(m_sr, bit_in);
      end
   end

   task automatic check(input string tag, input logic [7:0] exp);
      n_chk++;
      if (par_out !== exp) begin
         n_err++;
         $display("FAIL %s: par_out=%02h expected=%02h", tag, par_out, exp);
      end
   endtask

   task automatic cyc(input logic be, input logic b, input logic mk, input logic tk);
      bit_en = be; bit_in = b; byte_mark = mk; out_tick = tk;
      @(posedge clk);
      @(negedge clk);
      bit_en = 1'b0; byte_mark = 1'b0; out_tick = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v, input logic tick_last);
      for (int i = 7; i >= 0; i--)
         cyc(1'b1, v[i], i == 0, tick_last && i == 0);
   endtask

   initial begin
      #(20 * 200000);
      n_err++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int bcnt, tcnt, phase;
      logic be, mk, tk, prev_tk;
      void'($urandom(32'd20241));
      @(negedge clk);
      cyc(1'b1, 1'b1, 1'b1, 1'b1);
      check("R1 in reset", 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 8'h00);

      // R3: byte 0xA5 MSB first, then tick
      send_byte(8'hA5, 1'b0);
      check("R7 no tick yet", 8'h00);
      cyc(1'b0, 1'b0, 1'b0, 1'b1);
      check("R3 byte A5 at output", 8'hA5);

      // R2: strobe without bit_en, and bits without strobe
      cyc(1'b0, 1'b1, 1'b1, 1'b0);
      cyc(1'b0, 1'b0, 1'b0, 1'b1);
      check("R2 mark without bit ignored", 8'hA5);
      cyc(1'b0, 1'b1, 1'b0, 1'b0);
      send_byte(8'h3C, 1'b0);
      cyc(1'b0, 1'b0, 1'b0, 1'b1);
      check("R2 idle bits ignored", 8'h3C);

      // R4: load and tick on the same bit
      send_byte(8'h96, 1'b1);
      check("R4 same-cycle load not seen", 8'h3C);
      cyc(1'b0, 1'b0, 1'b0, 1'b1);
      check("R4 seen at next tick", 8'h96);

      // R5: two loads between ticks
      send_byte(8'h11, 1'b0);
      send_byte(8'hE7, 1'b0);
      cyc(1'b0, 1'b0, 1'b0, 1'b1);
      check("R5 newer byte wins", 8'hE7);

      // R6: tick with no load repeats
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 1'b0, 1'b1);
      check("R6 repeat held byte", 8'hE7);

      // random phase stream against the model
      bcnt = 0; tcnt = 3; phase = 7; prev_tk = 1'b0;
      for (int n = 0; n < 6000; n++) begin
         be = ($urandom % 4) != 0;
         mk = 1'b0; tk = 1'b0;
         if (be) begin
            mk = (bcnt % 8) == phase || ($urandom % 97) == 0;
            tk = tcnt == 7;
            tcnt = (tcnt + 1) % 8;
            bcnt++;
            if (($urandom % 150) == 0) phase = $urandom % 8;
         end
         cyc(be, 1'($urandom), mk, tk);
         if (tk) check("R4 random tick", m_out);
         else if (prev_tk) check("R6 random hold", m_out);
         else check("R7 random steady", m_out);
         prev_tk = tk;
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule